// File: doc/BRIEF.md
# Ethernet PHY Serial Management Slave

This block is the management-port end of an Ethernet PHY. A station manager clocks frames into it on the management clock and exchanges data with it on a single data line. Each frame names a PHY address and a register address, and asks for either a read or a write. The block keeps three registers: a control word at address 0, a read-only status word at address 1, and a configuration word at a parameter-selected address. The configuration word holds the PHY address and the enable for frames sent without preamble. The block exposes an isolate output that the datapath uses to detach itself from the media-independent interface.

The PHY address comes from five strap inputs, which are latched while reset is asserted. A strapped address of zero sets isolate at reset. After reset, only the control word's isolate bit moves isolate. The data line is split into an input, an output and an output enable, which the pad ring combines into one bidirectional pin with a pull-up. The block samples and drives on the rising edge of the management clock.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: At reset release the configuration word reads back with the strapped address in bits 7:3, the no-preamble enable (bit 1) at 1, and all other bits 0. The output enable is low.
- R2: At reset release, isolate is 1 when the strapped address is 00000 and 0 otherwise. The control word then reads 16'h3000 with bit 10 equal to isolate.
- R3: After reset, isolate always equals control bit 10 and changes only through a write to register 0. Writing 00000 into the address field leaves isolate unchanged.
- R4: A read frame carries start 01, opcode 10, a 5-bit PHY address and a 5-bit register address, each sent MSB first. The block releases the line during the first turnaround bit and drives 0 during the second. It then drives the 16 data bits MSB first and releases the line after the last bit.
- R5: A write frame uses opcode 01. It carries two turnaround bits that the block ignores, followed by 16 data bits MSB first. The written value of register 0 reads back unchanged.
- R6: Configuration bits 15:8, 2 and 0 read 0, and writes to them have no effect.
- R7: The status word reads 16'h7809, with bit 6 replaced by the no-preamble enable. Writes to it have no effect.
- R8: A frame whose PHY address differs from the stored address gets no drive on the line and changes no register.
- R9: With the no-preamble enable at 1, a frame is accepted with no preamble. With the enable at 0, a frame is accepted only after at least 32 consecutive ones, and a frame without preamble gets no response.
- R10: A frame with opcode 00 or 11 changes no register and gets no response.
- R11: The address field stays writable. Frames after such a write must carry the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all state moves on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; the strap inputs are latched while it is low |
| strap_addr | input | 5 | Strapped PHY address |
| mdio_i | input | 1 | Data line as seen from the pad |
| mdio_o | output | 1 | Data value driven toward the pad |
| mdio_oe | output | 1 | Pad output enable |
| isolate | output | 1 | Isolate request to the datapath (control bit 10) |

## Verification
A wrong frame state shows up at the ports within the same frame. The turnaround zero may appear a bit early or late, the output enable may stay high past the 16th data bit, or the block may answer a frame it should ignore. A bad address or enable register shows up in the next frame, which either goes unanswered or reads back the wrong configuration word. A bad isolate value shows up on the isolate pin in the cycle after the write that caused it. The status word shows up on its own bit 6.

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave #(
  parameter int          PRE_LEN   = 32,
  parameter logic [4:0]  VEND_REG  = 5'd20,
  parameter logic [15:0] CTRL_INIT = 16'h3000,
  parameter logic [15:0] STAT_BASE = 16'h7809
)(
  input  logic       mdc,
  input  logic       rst_n,
  input  logic [4:0] strap_addr,
  input  logic       mdio_i,
  output logic       mdio_o,
  output logic       mdio_oe,
  output logic       isolate
);
  localparam int PW = $clog2(PRE_LEN + 1);
  localparam logic [2:0] S_IDLE = 3'd0, S_START = 3'd1, S_HDR = 3'd2,
                         S_RD = 3'd3, S_WR = 3'd4, S_SKIP = 3'd5;

  logic [2:0]    st;
  logic [PW-1:0] ones;
  logic [4:0]    cnt;
  logic [11:0]   hdr;
  logic [4:0]    reg_a;
  logic [15:0]   sh;
  logic [15:0]   ctrl;
  logic [4:0]    phy_addr;
  logic          supp_en;
  logic [15:0]   rd_data;

  wire [11:0] hdr_n   = {hdr[10:0], mdio_i};
  wire        pre_ok  = supp_en || (ones == PW'(PRE_LEN));
  wire        hit     = (hdr_n[9:5] == phy_addr);
  wire        op_rd   = (hdr_n[11:10] == 2'b10);
  wire        op_wr   = (hdr_n[11:10] == 2'b01);
  wire        wr_fire = (st == S_WR) && (cnt == 5'd17);
  wire [15:0] wr_data = {sh[14:0], mdio_i};

  assign isolate = ctrl[10];

  always_comb begin
    if (reg_a == 5'd0)          rd_data = ctrl;
    else if (reg_a == 5'd1)     rd_data = (STAT_BASE & ~16'h0040) | {9'b0, supp_en, 6'b0};
    else if (reg_a == VEND_REG) rd_data = {8'h00, phy_addr, 1'b0, supp_en, 1'b0};
    else                        rd_data = 16'h0000;
  end

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ones    <= '0;
      cnt     <= '0;
      hdr     <= '0;
      reg_a   <= '0;
      sh      <= '0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (mdio_i) begin
            if (ones != PW'(PRE_LEN)) ones <= ones + 1'b1;
          end else begin
            if (pre_ok) st <= S_START;
            ones <= '0;
          end
        end
        S_START: begin
          st  <= mdio_i ? S_HDR : S_IDLE;
          cnt <= '0;
        end
        S_HDR: begin
          hdr <= hdr_n;
          cnt <= cnt + 1'b1;
          if (cnt == 5'd11) begin
            cnt   <= '0;
            reg_a <= hdr_n[4:0];
            if (hit && op_rd)      st <= S_RD;
            else if (hit && op_wr) st <= S_WR;
            else                   st <= S_SKIP;
          end
        end
        S_RD: begin
          cnt <= cnt + 1'b1;
          if (cnt == 5'd0) begin
            mdio_oe <= 1'b1;
            mdio_o  <= 1'b0;
            sh      <= rd_data;
          end else if (cnt <= 5'd16) begin
            mdio_o <= sh[15];
            sh     <= {sh[14:0], 1'b0};
          end else begin
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b0;
            st      <= S_IDLE;
          end
        end
        S_WR: begin
          cnt <= cnt + 1'b1;
          sh  <= wr_data;
          if (cnt == 5'd17) st <= S_IDLE;
        end
        default: begin
          cnt <= cnt + 1'b1;
          if (cnt >= 5'd17) st <= S_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= (CTRL_INIT & ~16'h0400) | {5'b0, (strap_addr == 5'd0), 10'b0};
      phy_addr <= strap_addr;
      supp_en  <= 1'b1;
    end else if (wr_fire) begin
      if (reg_a == 5'd0) ctrl <= wr_data;
      else if (reg_a == VEND_REG) begin
        phy_addr <= wr_data[7:3];
        supp_en  <= wr_data[1];
      end
    end
  end
endmodule

module mdio_mgmt_slave_chk #(
  parameter logic [4:0] VEND_REG = 5'd20
)(
  input logic       mdc,
  input logic       rst_n,
  input logic       mdio_o,
  input logic       mdio_oe,
  input logic       isolate,
  input logic [2:0] st,
  input logic       wr_fire,
  input logic [4:0] reg_a,
  input logic [4:0] phy_addr,
  input logic       supp_en
);
  logic [4:0] oe_run;
  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n)       oe_run <= '0;
    else if (mdio_oe) oe_run <= (oe_run == 5'd31) ? oe_run : oe_run + 1'b1;
    else              oe_run <= '0;
  end

  a_r3_iso_only_by_write: assert property (@(posedge mdc) disable iff (!rst_n)
    !(wr_fire && reg_a == 5'd0) |=> $stable(isolate));
  a_r11_addr_only_by_write: assert property (@(posedge mdc) disable iff (!rst_n)
    !(wr_fire && reg_a == VEND_REG) |=> $stable(phy_addr));
  a_r9_enable_only_by_write: assert property (@(posedge mdc) disable iff (!rst_n)
    !(wr_fire && reg_a == VEND_REG) |=> $stable(supp_en));
  a_r4_turnaround_zero: assert property (@(posedge mdc) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);
  a_r4_drive_window: assert property (@(posedge mdc) disable iff (!rst_n)
    oe_run <= 5'd17);
  a_r8_quiet_when_idle: assert property (@(posedge mdc) disable iff (!rst_n)
    (st == 3'd0) |-> !mdio_oe);
endmodule

bind mdio_mgmt_slave mdio_mgmt_slave_chk #(.VEND_REG(VEND_REG)) chk_i (
  .mdc(mdc), .rst_n(rst_n), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .isolate(isolate), .st(st), .wr_fire(wr_fire), .reg_a(reg_a),
  .phy_addr(phy_addr), .supp_en(supp_en));

// File: tb/mdio_mgmt_slave_tb.sv
module mdio_mgmt_slave_tb_top;
  localparam logic [4:0] VREG = 5'd20;
  logic clk = 1'b0, rst_n = 1'b0, mdio_i = 1'b1;
  logic [4:0] strap = 5'd0;
  logic mdio_o, mdio_oe, isolate;
  int errors = 0, checks = 0;

  logic [15:0] m_ctrl;
  logic [4:0]  m_addr;
  logic        m_supp;

  always #10 clk = ~clk;

  mdio_mgmt_slave #(.VEND_REG(VREG)) dut_i (
    .mdc(clk), .rst_n(rst_n), .strap_addr(strap), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .isolate(isolate));

  function automatic logic [15:0] exp_rd(input logic [4:0] r);
    if (r == 5'd0)      return m_ctrl;
    else if (r == 5'd1) return 16'h7809 | {9'b0, m_supp, 6'b0};
    else if (r == VREG) return {8'h00, m_addr, 1'b0, m_supp, 1'b0};
    else                return 16'h0000;
  endfunction

  function automatic void model_wr(input logic [4:0] r, input logic [15:0] d);
    if (r == 5'd0) m_ctrl = d;
    else if (r == VREG) begin m_addr = d[7:3]; m_supp = d[1]; end
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    @(negedge clk); mdio_i = b;
  endtask

  task automatic hdr(input int pre, input logic [1:0] op, input logic [4:0] p, input logic [4:0] r);
    for (int i = 0; i < pre; i++) bit_out(1'b1);
    bit_out(1'b0); bit_out(1'b1);
    bit_out(op[1]); bit_out(op[0]);
    for (int i = 4; i >= 0; i--) bit_out(p[i]);
    for (int i = 4; i >= 0; i--) bit_out(r[i]);
  endtask

  task automatic do_read(input int pre, input logic [1:0] op, input logic [4:0] p, input logic [4:0] r,
                         output logic [15:0] v, output bit resp, output bit clean);
    bit ta1, all_oe, any_oe;
    hdr(pre, op, p, r);
    @(negedge clk); ta1 = mdio_oe; any_oe = mdio_oe; mdio_i = 1'b1;
    @(negedge clk); resp = mdio_oe && !mdio_o; any_oe |= mdio_oe;
    all_oe = 1'b1; v = '0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); v = {v[14:0], mdio_o}; all_oe &= mdio_oe; any_oe |= mdio_oe;
    end
    @(negedge clk);
    clean = !ta1 && !mdio_oe;
    if (!resp) clean = clean && !any_oe;
    else       clean = clean && all_oe;
  endtask

  task automatic do_write(input int pre, input logic [1:0] op, input logic [4:0] p, input logic [4:0] r,
                          input logic [15:0] d);
    hdr(pre, op, p, r);
    bit_out(1'b1); bit_out(1'b0);
    for (int i = 15; i >= 0; i--) bit_out(d[i]);
    @(negedge clk); mdio_i = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd_chk(input int pre, input logic [4:0] r, input string req);
    logic [15:0] v; bit resp, clean;
    do_read(pre, 2'b10, m_addr, r, v, resp, clean);
    chk(resp && clean && v == exp_rd(r), req, v, exp_rd(r));
  endtask

  task automatic do_reset(input logic [4:0] s);
    rst_n = 1'b0; strap = s; mdio_i = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_addr = s; m_supp = 1'b1;
    m_ctrl = 16'h3000 | {5'b0, (s == 5'd0), 10'b0};
    @(negedge clk);
  endtask

  initial begin
    #(20ns * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] v; bit resp, clean;
    void'($urandom(32'd2024));

    do_reset(5'd0);
    chk(isolate == 1'b1, "R2 zero strap isolates", {15'b0, isolate}, 16'h1);
    chk(mdio_oe == 1'b0, "R1 line released at reset", {15'b0, mdio_oe}, 16'h0);
    rd_chk(32, VREG, "R1 config word after reset");
    rd_chk(32, 5'd0, "R2 control after reset");

    do_write(32, 2'b01, 5'd0, 5'd0, 16'h3000);
    chk(isolate == 1'b0, "R3 clear isolate by write", {15'b0, isolate}, 16'h0);
    model_wr(5'd0, 16'h3000);
    do_write(32, 2'b01, 5'd0, VREG, 16'h0000);
    model_wr(VREG, 16'h0000);
    chk(isolate == 1'b0, "R3 zero address write keeps isolate", {15'b0, isolate}, 16'h0);
    do_write(32, 2'b01, 5'd0, VREG, 16'hFFFF);
    model_wr(VREG, 16'hFFFF);
    rd_chk(32, VREG, "R6 reserved bits read zero");
    rd_chk(32, VREG, "R11 new address answers");
    do_read(32, 2'b10, 5'd0, VREG, v, resp, clean);
    chk(!resp && clean, "R11 old address silent", {14'b0, resp, clean}, 16'h1);

    do_reset(5'h0B);
    chk(isolate == 1'b0, "R2 nonzero strap not isolated", {15'b0, isolate}, 16'h0);
    rd_chk(32, VREG, "R1 strap in address field");
    rd_chk(32, 5'd1, "R7 status with enable set");
    do_write(32, 2'b01, m_addr, 5'd1, 16'hFFFF);
    rd_chk(32, 5'd1, "R7 status ignores write");
    do_write(32, 2'b01, m_addr, 5'd0, 16'hA5C3);
    model_wr(5'd0, 16'hA5C3);
    rd_chk(32, 5'd0, "R5 control write readback");
    chk(isolate == 1'b1, "R3 isolate follows bit 10", {15'b0, isolate}, 16'h1);
    do_write(32, 2'b01, m_addr, 5'd0, 16'h3000);
    model_wr(5'd0, 16'h3000);
    chk(isolate == 1'b0, "R3 isolate cleared", {15'b0, isolate}, 16'h0);

    do_write(32, 2'b01, m_addr ^ 5'd1, 5'd0, 16'hFFFF);
    rd_chk(32, 5'd0, "R8 mismatched write ignored");
    do_read(32, 2'b10, m_addr ^ 5'd4, 5'd0, v, resp, clean);
    chk(!resp && clean, "R8 mismatched read silent", {14'b0, resp, clean}, 16'h1);
    do_write(32, 2'b11, m_addr, 5'd0, 16'hFFFF);
    do_write(32, 2'b00, m_addr, 5'd0, 16'hFFFF);
    rd_chk(32, 5'd0, "R10 bad opcode writes ignored");
    do_read(32, 2'b11, m_addr, 5'd0, v, resp, clean);
    chk(!resp && clean, "R10 bad opcode read silent", {14'b0, resp, clean}, 16'h1);

    rd_chk(0, 5'd0, "R9 no preamble accepted when enabled");
    do_write(32, 2'b01, m_addr, VREG, {8'h00, m_addr, 3'b000});
    model_wr(VREG, {8'h00, m_addr, 3'b000});
    rd_chk(32, 5'd1, "R7 status mirrors cleared enable");
    do_read(0, 2'b10, m_addr, 5'd0, v, resp, clean);
    chk(!resp && clean, "R9 no preamble rejected", {14'b0, resp, clean}, 16'h1);
    rd_chk(32, 5'd0, "R9 full preamble accepted");

    for (int n = 0; n < 80; n++) begin
      logic [4:0] r;
      logic [15:0] d;
      int pre;
      bit miss;
      case ($urandom_range(0, 3))
        0: r = 5'd0;
        1: r = 5'd1;
        2: r = VREG;
        default: r = 5'd7;
      endcase
      d = 16'($urandom());
      pre = (m_supp && $urandom_range(0, 1) == 1) ? 0 : 32;
      miss = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 1) == 1) begin
        do_write(pre, 2'b01, miss ? (m_addr ^ 5'd2) : m_addr, r, d);
        if (!miss) model_wr(r, d);
        chk(isolate == m_ctrl[10], "R3 random isolate", {15'b0, isolate}, {15'b0, m_ctrl[10]});
      end else if (miss) begin
        do_read(pre, 2'b10, m_addr ^ 5'd2, r, v, resp, clean);
        chk(!resp && clean, "R8 random mismatch silent", {14'b0, resp, clean}, 16'h1);
      end else begin
        rd_chk(pre, r, "R4 random read");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule